// File: doc/BRIEF.md
# Instruction-boundary interrupt sampler

This block models how a processor sees its encoded interrupt priority pins. On every bus cycle (reads and writes of any size, and instruction-stream fetches) it captures the level on the pins into a holding register. A master enable gates that capture: while the master enable is low, the captured value is zero.

At each instruction boundary the block registers the level handed to the core for its take-interrupt decision. Normally that level is the smaller of the live pin level and the level captured at the most recent bus access. A request that rises after an instruction's last bus cycle is therefore taken one instruction later. A request that has already fallen is never presented stale. A stopped core uses the live level directly, so it can wake without a bus cycle. When the latency feature is switched off, the live level is always passed through.

Top module: `ipl_boundary_sampler`

## Requirements
- R1: After reset the boundary output is 0 and the captured level is 0. A boundary with no bus access since reset, latency on and not stopped, presents 0 whatever the live level is.
- R2: On a cycle with the bus strobe high and the master enable high, the live level is captured.
- R3: The captured level keeps its value on cycles without the bus strobe.
- R4: On a boundary with latency on and not stopped, the output becomes min(live, captured) one clock later.
- R5: A level that rises after the last bus access is presented only at a boundary that follows a later bus access.
- R6: If the live level is below the captured level at a boundary, the live level is presented.
- R7: On a boundary with the stopped flag high, the live level is presented.
- R8: On a boundary with latency off, the live level is presented.
- R9: A bus access with the master enable low captures 0.
- R10: The output changes only on the clock after a boundary strobe.
- R11: When the bus strobe and the boundary strobe fall in the same cycle, the boundary uses the level captured before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| live_lvl | input | LEVEL_W | Live encoded interrupt level on the pins |
| bus_stb | input | 1 | High for one cycle per bus access |
| bnd_stb | input | 1 | High for one cycle per instruction boundary |
| core_stopped | input | 1 | Core is in the stopped state |
| lat_en | input | 1 | Latency feature enable (0 = pass the live level through) |
| master_en | input | 1 | Master interrupt enable gating the capture |
| core_lvl | output | LEVEL_W | Registered level for the take-interrupt decision |

## Verification
The main function is tried with live levels that rise between a bus access and the next boundary, which shows whether the block delays the level by one instruction. It is also tried with levels that fall below the captured value, which shows whether the minimum is taken or a stale level is presented. Stopped, latency-off and master-enable-low cycles are mixed with the same level histories, so each selection path can be told apart from the minimum path. A sweep over all pairs of captured and live levels separates a true minimum from a maximum or a one-sided pick. Same-cycle strobes separate the old captured value from the newly captured one.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
   typedef enum logic [1:0] {
      SEL_HOLD = 2'd0,
      SEL_LIVE = 2'd1,
      SEL_MIN  = 2'd2
   } sel_e;
endpackage

// File: rtl/ipl_pin_latch.sv
module ipl_pin_latch #(
   parameter int LEVEL_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEVEL_W-1:0] live_lvl,
   input  logic               bus_stb,
   input  logic               master_en,
   output logic [LEVEL_W-1:0] held_lvl
);
   localparam logic [LEVEL_W-1:0] ZERO = '0;

   generate
      if (LEVEL_W < 1 || LEVEL_W > 8) begin : g_bad_width
         $error("ipl_pin_latch: LEVEL_W out of range");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         held_lvl <= ZERO;
      else if (bus_stb)
         held_lvl <= master_en ? live_lvl : ZERO;
   end

   assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_stb |=> $stable(held_lvl));
   assert_gate_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stb && !master_en) |=> held_lvl == ZERO);
   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_stb && master_en) |=> held_lvl == $past(live_lvl));
endmodule

// File: rtl/ipl_boundary_sel.sv
module ipl_boundary_sel
   import ipl_pkg::*;
#(
   parameter int LEVEL_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEVEL_W-1:0] live_lvl,
   input  logic [LEVEL_W-1:0] held_lvl,
   input  logic               bnd_stb,
   input  logic               core_stopped,
   input  logic               lat_en,
   output logic [LEVEL_W-1:0] core_lvl
);
   sel_e               sel;
   logic [LEVEL_W-1:0] min_lvl;
   logic [LEVEL_W-1:0] nxt_lvl;

   always_comb begin
      if (!bnd_stb)
         sel = SEL_HOLD;
      else if (!lat_en || core_stopped)
         sel = SEL_LIVE;
      else
         sel = SEL_MIN;
   end

   assign min_lvl = (held_lvl < live_lvl) ? held_lvl : live_lvl;

   always_comb begin
      case (sel)
         SEL_LIVE: nxt_lvl = live_lvl;
         SEL_MIN:  nxt_lvl = min_lvl;
         default:  nxt_lvl = core_lvl;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         core_lvl <= '0;
      else
         core_lvl <= nxt_lvl;
   end

   assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd_stb |=> $stable(core_lvl));
   assert_not_above_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_stb |=> core_lvl <= $past(live_lvl));
   assert_not_above_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_stb && lat_en && !core_stopped) |=> core_lvl <= $past(held_lvl));
   assert_stopped_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_stb && core_stopped) |=> core_lvl == $past(live_lvl));
   assert_bypass_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_stb && !lat_en) |=> core_lvl == $past(live_lvl));
endmodule

// File: rtl/ipl_boundary_sampler.sv
module ipl_boundary_sampler #(
   parameter int LEVEL_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LEVEL_W-1:0] live_lvl,
   input  logic               bus_stb,
   input  logic               bnd_stb,
   input  logic               core_stopped,
   input  logic               lat_en,
   input  logic               master_en,
   output logic [LEVEL_W-1:0] core_lvl
);
   logic [LEVEL_W-1:0] held_lvl;

   ipl_pin_latch #(.LEVEL_W(LEVEL_W)) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .live_lvl  (live_lvl),
      .bus_stb   (bus_stb),
      .master_en (master_en),
      .held_lvl  (held_lvl)
   );

   ipl_boundary_sel #(.LEVEL_W(LEVEL_W)) u_sel (
      .clk          (clk),
      .rst_n        (rst_n),
      .live_lvl     (live_lvl),
      .held_lvl     (held_lvl),
      .bnd_stb      (bnd_stb),
      .core_stopped (core_stopped),
      .lat_en       (lat_en),
      .core_lvl     (core_lvl)
   );

   assert_reset_zero_R1: assert property (@(posedge clk)
      !rst_n |=> core_lvl == '0);
endmodule

// File: tb/ipl_boundary_sampler_bench.sv
module ipl_boundary_sampler_bench;
   localparam int CLK_PERIOD = 10;
   localparam int LW = 3;

   typedef struct {
      logic [LW-1:0] exp;
      string         tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [LW-1:0] live_lvl = '0;
   logic          bus_stb = 1'b0;
   logic          bnd_stb = 1'b0;
   logic          core_stopped = 1'b0;
   logic          lat_en = 1'b1;
   logic          master_en = 1'b1;
   logic [LW-1:0] core_lvl;

   item_t         sb[$];
   int            total = 0;
   int            bad = 0;
   bit            done = 1'b0;
   logic [LW-1:0] m_held = '0;
   logic [LW-1:0] m_out = '0;

   ipl_boundary_sampler #(.LEVEL_W(LW)) u_ipl_boundary_sampler (
      .clk          (clk),
      .rst_n        (rst_n),
      .live_lvl     (live_lvl),
      .bus_stb      (bus_stb),
      .bnd_stb      (bnd_stb),
      .core_stopped (core_stopped),
      .lat_en       (lat_en),
      .master_en    (master_en),
      .core_lvl     (core_lvl)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Drive one cycle and push the expected output after the next edge.
   task automatic step(input logic [LW-1:0] lv, input logic bus, input logic bnd,
                       input logic stp, input logic en, input logic mie,
                       input string tag);
      item_t it;
      @(negedge clk);
      live_lvl = lv; bus_stb = bus; bnd_stb = bnd;
      core_stopped = stp; lat_en = en; master_en = mie;
      if (bnd) begin
         if (!en || stp) m_out = lv;
         else m_out = (m_held < lv) ? m_held : lv;
      end
      if (bus) m_held = mie ? lv : '0;
      it.exp = m_out;
      it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic check_now(input logic [LW-1:0] exp, input string tag);
      total++;
      if (core_lvl !== exp) begin
         bad++;
         $display("FAIL %s: core_lvl=%0d expected=%0d", tag, core_lvl, exp);
      end
   endtask

   // Monitor: compare after each edge.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check_now(it.exp, it.tag);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog: run hung, actual=expired expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_now('0, "R1 reset output");
      rst_n = 1'b1;
      // R1: latch starts at 0, so min gives 0
      step(3'd5, 0, 1, 0, 1, 1, "R1 boundary before any access");
      // R2/R4: capture then boundary
      step(3'd5, 1, 0, 0, 1, 1, "R2 capture");
      step(3'd5, 0, 1, 0, 1, 1, "R4 min after capture");
      // R3/R10/R5: level rises after last access
      step(3'd7, 0, 0, 0, 1, 1, "R10 hold no boundary");
      step(3'd7, 0, 0, 0, 1, 1, "R3 hold no access");
      step(3'd7, 0, 1, 0, 1, 1, "R5 late rise not yet seen");
      step(3'd7, 1, 0, 0, 1, 1, "R5 access captures rise");
      step(3'd7, 0, 1, 0, 1, 1, "R5 rise seen next boundary");
      // R6: drop below captured
      step(3'd2, 0, 1, 0, 1, 1, "R6 dropped level not stale");
      // R7: stopped uses live
      step(3'd2, 1, 0, 0, 1, 1, "R2 capture 2");
      step(3'd6, 0, 1, 1, 1, 1, "R7 stopped live");
      step(3'd6, 0, 1, 0, 1, 1, "R4 running min again");
      // R8: latency off
      step(3'd6, 0, 1, 0, 0, 1, "R8 bypass live");
      step(3'd1, 0, 1, 0, 0, 1, "R8 bypass lower");
      // R9: master enable low captures 0
      step(3'd6, 1, 0, 0, 1, 0, "R9 gated capture");
      step(3'd6, 0, 1, 0, 1, 1, "R9 presents 0");
      // R11: same-cycle strobes
      step(3'd4, 1, 1, 0, 1, 1, "R11 uses old capture");
      step(3'd4, 0, 1, 0, 1, 1, "R11 new capture next boundary");
      step(3'd0, 0, 0, 0, 1, 1, "R10 hold after live drop");
      // Sweep every captured/live pair
      for (int h = 0; h < 8; h++) begin
         for (int l = 0; l < 8; l++) begin
            step(LW'(h), 1, 0, 0, 1, 1, "R2 sweep capture");
            step(LW'(l), 0, 1, 0, 1, 1, "R4 sweep min");
            step(LW'(l), 0, 1, 1, 1, 1, "R7 sweep stopped");
         end
      end
      // R1 again: reset mid-run clears both
      @(negedge clk);
      bus_stb = 1'b0; bnd_stb = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      m_held = '0; m_out = '0;
      #1;
      check_now('0, "R1 reset mid-run");
      step(3'd3, 0, 1, 0, 1, 1, "R1 latch cleared by reset");
      step(3'd3, 0, 0, 0, 1, 1, "R10 final hold");
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule